// File: doc/BRIEF.md
# Serial NAND Power-Up Sequencer

This block takes a serial NAND flash from power-up to a usable state. It talks to the flash through a byte-level command/response port. For each transaction the sequencer presents up to four command bytes, a count of bytes to send and a count of bytes to receive. An external shift engine carries out the transaction and returns the received bytes with a one-cycle `rsp_valid` pulse.

After a `start` pulse the sequencer runs these steps in order:

- It resets the device and polls the busy bit until it clears.
- It reads the three-byte device identifier and looks it up in a parameter table of supported parts.
- It clears the write-protect bits, then sets buffer mode, then enables on-die ECC. Each of these is a read-modify-write of a status register, and every write is followed by busy polling.
- It reads the ECC setting back to confirm it.
- If the table marks the part as multi-die, it selects the second die and clears protection again.

The block ends in one of two states, both held until reset:

- Done: the matched table index and geometry are shown on the outputs.
- Error: the error flag is set.

FSM states:

| State | Action |
|---|---|
| `S_IDLE` | Wait for `start`. |
| `S_RESET` | Send the reset opcode. |
| `S_POLL` | Busy poll. |
| `S_ID` | Read the identifier. |
| `S_MATCH` | Table lookup. No command is issued. |
| `S_RD` | Status register read. |
| `S_WR` | Status register write. |
| `S_ECC_RB` | ECC readback. |
| `S_DIE` | Die select. |
| `S_DONE` | Terminal state, success. |
| `S_FAIL` | Terminal state, error. |

FSM transitions:

- `S_IDLE`→`S_RESET` on start.
- `S_RESET`→`S_POLL`.
- `S_POLL` stays in `S_POLL` while busy.
- `S_POLL`→`S_ID` after reset.
- `S_POLL`→`S_RD` (next step), `S_ECC_RB` or `S_DONE` after a write.
- `S_ID`→`S_MATCH`.
- `S_MATCH`→`S_RD` or `S_FAIL`.
- `S_RD`→`S_WR`.
- `S_WR`→`S_POLL`.
- `S_ECC_RB`→`S_DIE`, `S_DONE` or `S_FAIL`.
- `S_DIE`→`S_RD`.
- Any command state →`S_FAIL` on a transport error.

Top module: `snand_init_seq`

## Requirements
- R1: A `start` pulse in idle issues the reset command first: byte 0xFF, 1 byte sent, 0 received. Busy polling follows. `start` has no effect outside idle.
- R2: Busy polling sends 0x0F,0xC0 (2 sent, 1 received) and repeats until received bit 0 is clear. The identifier read sends 0x9F (1 sent, 4 received). The ID is the first three received bytes taken big-endian (`rsp_data[31:8]`); the fourth byte is ignored.
- R3: An ID that matches no table entry ends in error, and no status register is written.
- R4: A table match whose top ID byte is not 0xEF ends in error, and no status register is written.
- R5: Unprotect reads register 1 with 0x05,0xA0 and writes it back with 0x01,0xA0,(value AND 0x83).
- R6: After unprotect, register 2 is read with 0x0F,0xB0 and written with 0x01,0xB0 and bit 3 (0x08) set. It is then read and written again with bit 4 (0x10) set. Every status write is followed by busy polling until idle, before any other command.
- R7: After the ECC write, register 2 is read back with 0x0F,0xB0. If bit 4 is clear, the sequence ends in error and issues no further command.
- R8: A part flagged multi-die gets 0xC2 followed by the die number (default 1), then a second unprotect. A single-die part gets no 0xC2.
- R9: On success, `done`=1, `error`=0, and `id_index` and the geometry outputs show the matched entry. Done and error never coincide, stay held until reset, and no command is issued after either.
- R10: `POLL_MAX` consecutive busy responses in one poll end in error.
- R11: A response with `rsp_err` set ends in error at once. The error stays set until reset.
- R12: While `cmd_valid` is high and no response has arrived, `cmd_valid` and all command fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the sequence (accepted in idle only) |
| cmd_valid | output | 1 | A transaction is requested |
| cmd_bytes | output | 32 | Command bytes, first byte in [31:24] |
| cmd_ntx | output | 3 | Number of command bytes to send |
| cmd_nrx | output | 3 | Number of bytes to receive |
| rsp_valid | input | 1 | Transaction complete (one cycle) |
| rsp_data | input | 32 | Received bytes right-aligned, last byte in [7:0] |
| rsp_err | input | 1 | Transport error on this transaction |
| done | output | 1 | Sequence completed successfully |
| error | output | 1 | Sequence aborted |
| id_index | output | IDX_W | Matched table entry |
| part_page | output | 16 | Page size of matched part in bytes |
| part_spare | output | 8 | Spare size of matched part in bytes |
| part_blk | output | 16 | Pages per block of matched part |

## Verification
The hardest paths to reach from the ports are the ECC readback failure on a multi-die part and the poll timeout. Both are driven by a behavioural flash model inside the bench:

- ECC failure: the model's register 2 can be set so that bit 4 cannot be set. The readback then fails after an otherwise valid sequence, and the test confirms that the die select never follows.
- Poll timeout: the model can also report busy on every poll.

The model also records every command. From that record the bench checks the following:

- The written register values are right.
- No command other than a poll ever follows a status write before idle is seen.
- The command fields held steady while each response was pending.

// File: rtl/snand_init_pkg.sv
package snand_init_pkg;

    typedef struct packed {
        logic [23:0] id;
        logic [15:0] page_bytes;
        logic [7:0]  spare_bytes;
        logic [15:0] blk_pages;
        logic        multi_die;
    } part_t;

    localparam int PART_COUNT = 3;

    localparam logic [7:0] OP_RESET  = 8'hFF;
    localparam logic [7:0] OP_IDRD   = 8'h9F;
    localparam logic [7:0] OP_SRRD_A = 8'h05;
    localparam logic [7:0] OP_SRRD_B = 8'h0F;
    localparam logic [7:0] OP_SRWR   = 8'h01;
    localparam logic [7:0] OP_DIESEL = 8'hC2;
    localparam logic [7:0] AD_REG1   = 8'hA0;
    localparam logic [7:0] AD_REG2   = 8'hB0;
    localparam logic [7:0] AD_REG3   = 8'hC0;
    localparam logic [7:0] VENDOR_OK = 8'hEF;

    function automatic part_t part_entry(input int i);
        part_t p;
        case (i)
            0:       p = '{24'hEFAA21, 16'd2048, 8'd64,  16'd64, 1'b0};
            1:       p = '{24'hEFAB21, 16'd2048, 8'd64,  16'd64, 1'b1};
            default: p = '{24'h2C242C, 16'd2048, 8'd128, 16'd64, 1'b0};
        endcase
        return p;
    endfunction

    typedef enum logic [3:0] {
        S_IDLE, S_RESET, S_POLL, S_ID, S_MATCH, S_RD, S_WR,
        S_ECC_RB, S_DIE, S_DONE, S_FAIL
    } seq_state_t;

endpackage

// File: rtl/snand_id_match.sv
module snand_id_match
    import snand_init_pkg::*;
#(
    parameter int N     = PART_COUNT,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [23:0]      id,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output part_t            entry
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = (id == part_entry(g).id);
    end

    always_comb begin
        hit   = 1'b0;
        idx   = '0;
        entry = part_entry(0);
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit   = 1'b1;
                idx   = IDX_W'(i);
                entry = part_entry(i);
            end
        end
    end
endmodule

// File: rtl/snand_poll_limit.sv
module snand_poll_limit #(
    parameter int POLL_MAX = 16,
    localparam int CW = $clog2(POLL_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic busy_seen,
    output logic last_try
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (busy_seen)  cnt <= cnt + 1'b1;
    end

    assign last_try = (cnt >= CW'(POLL_MAX - 1));
endmodule

// File: rtl/snand_init_seq.sv
module snand_init_seq
    import snand_init_pkg::*;
#(
    parameter int N          = PART_COUNT,
    parameter int POLL_MAX   = 16,
    parameter logic [7:0] DIE_NUM = 8'h01,
    localparam int IDX_W     = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             cmd_valid,
    output logic [31:0]      cmd_bytes,
    output logic [2:0]       cmd_ntx,
    output logic [2:0]       cmd_nrx,
    input  logic             rsp_valid,
    input  logic [31:0]      rsp_data,
    input  logic             rsp_err,
    output logic             done,
    output logic             error,
    output logic [IDX_W-1:0] id_index,
    output logic [15:0]      part_page,
    output logic [7:0]       part_spare,
    output logic [15:0]      part_blk
);
    seq_state_t       state, nxt;
    logic [1:0]       step;
    logic             post_reset;
    logic [7:0]       sr_val;
    logic [23:0]      id_q;
    logic [IDX_W-1:0] idx_q;
    part_t            part_q;

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    part_t            m_entry;
    logic             last_try;
    logic             busy_rsp;
    logic [7:0]       step_addr, step_rdop, step_wval;

    snand_id_match #(.N(N), .IDX_W(IDX_W)) u_match (
        .id(id_q), .hit(m_hit), .idx(m_idx), .entry(m_entry)
    );

    assign busy_rsp = (state == S_POLL) && rsp_valid && !rsp_err && rsp_data[0];

    snand_poll_limit #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk(clk), .rst_n(rst_n), .clear(state != S_POLL),
        .busy_seen(busy_rsp), .last_try(last_try)
    );

    // per-step register selection and modification
    always_comb begin
        unique case (step)
            2'd1: begin step_addr = AD_REG2; step_rdop = OP_SRRD_B; step_wval = sr_val | 8'h08; end
            2'd2: begin step_addr = AD_REG2; step_rdop = OP_SRRD_B; step_wval = sr_val | 8'h10; end
            default: begin step_addr = AD_REG1; step_rdop = OP_SRRD_A; step_wval = sr_val & 8'h83; end
        endcase
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_RESET;
            S_RESET:  if (rsp_valid) nxt = rsp_err ? S_FAIL : S_POLL;
            S_POLL: begin
                if (rsp_valid) begin
                    if (rsp_err)               nxt = S_FAIL;
                    else if (rsp_data[0])      nxt = last_try ? S_FAIL : S_POLL;
                    else if (post_reset)       nxt = S_ID;
                    else if (step == 2'd2)     nxt = S_ECC_RB;
                    else if (step == 2'd3)     nxt = S_DONE;
                    else                       nxt = S_RD;
                end
            end
            S_ID:     if (rsp_valid) nxt = rsp_err ? S_FAIL : S_MATCH;
            S_MATCH:  nxt = (m_hit && m_entry.id[23:16] == VENDOR_OK) ? S_RD : S_FAIL;
            S_RD:     if (rsp_valid) nxt = rsp_err ? S_FAIL : S_WR;
            S_WR:     if (rsp_valid) nxt = rsp_err ? S_FAIL : S_POLL;
            S_ECC_RB: begin
                if (rsp_valid) begin
                    if (rsp_err || !rsp_data[4]) nxt = S_FAIL;
                    else if (part_q.multi_die)   nxt = S_DIE;
                    else                         nxt = S_DONE;
                end
            end
            S_DIE:    if (rsp_valid) nxt = rsp_err ? S_FAIL : S_RD;
            S_DONE:   nxt = S_DONE;
            S_FAIL:   nxt = S_FAIL;
            default:  nxt = S_FAIL;
        endcase
    end

    // state and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            step       <= 2'd0;
            post_reset <= 1'b1;
            sr_val     <= '0;
            id_q       <= '0;
            idx_q      <= '0;
            part_q     <= '0;
        end else begin
            state <= nxt;
            if (state == S_ID && rsp_valid)  id_q <= rsp_data[31:8];
            if (state == S_MATCH) begin
                idx_q  <= m_idx;
                part_q <= m_entry;
            end
            if (state == S_RD && rsp_valid)  sr_val <= rsp_data[7:0];
            if (state == S_WR && rsp_valid)  post_reset <= 1'b0;
            if (state == S_POLL && nxt == S_RD && !post_reset) step <= step + 2'd1;
            if (state == S_DIE && rsp_valid) step <= 2'd3;
        end
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b1;
        cmd_bytes = '0;
        cmd_ntx   = 3'd0;
        cmd_nrx   = 3'd0;
        unique case (state)
            S_RESET:  begin cmd_bytes = {OP_RESET, 24'h0};             cmd_ntx = 3'd1; end
            S_POLL:   begin cmd_bytes = {OP_SRRD_B, AD_REG3, 16'h0};   cmd_ntx = 3'd2; cmd_nrx = 3'd1; end
            S_ID:     begin cmd_bytes = {OP_IDRD, 24'h0};              cmd_ntx = 3'd1; cmd_nrx = 3'd4; end
            S_RD:     begin cmd_bytes = {step_rdop, step_addr, 16'h0}; cmd_ntx = 3'd2; cmd_nrx = 3'd1; end
            S_WR:     begin cmd_bytes = {OP_SRWR, step_addr, step_wval, 8'h0}; cmd_ntx = 3'd3; end
            S_ECC_RB: begin cmd_bytes = {OP_SRRD_B, AD_REG2, 16'h0};   cmd_ntx = 3'd2; cmd_nrx = 3'd1; end
            S_DIE:    begin cmd_bytes = {OP_DIESEL, DIE_NUM, 16'h0};   cmd_ntx = 3'd2; end
            default:  cmd_valid = 1'b0;
        endcase
        done       = (state == S_DONE);
        error      = (state == S_FAIL);
        id_index   = idx_q;
        part_page  = part_q.page_bytes;
        part_spare = part_q.spare_bytes;
        part_blk   = part_q.blk_pages;
    end
endmodule

// File: rtl/snand_init_seq_chk.sv
module snand_init_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [31:0] cmd_bytes,
    input logic [2:0]  cmd_ntx,
    input logic [2:0]  cmd_nrx,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic        done,
    input logic        error
);
    p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rsp_valid) |=> (cmd_valid && $stable(cmd_bytes) && $stable(cmd_ntx) && $stable(cmd_nrx)));

    p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_done_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_quiet_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !cmd_valid);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    p_err_on_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && rsp_valid && rsp_err) |=> error);
endmodule

bind snand_init_seq snand_init_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bytes(cmd_bytes),
    .cmd_ntx(cmd_ntx), .cmd_nrx(cmd_nrx), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .done(done), .error(error)
);

// File: tb/snand_init_seq_bench.sv
module snand_init_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cmd_valid;
    logic [31:0] cmd_bytes;
    logic [2:0]  cmd_ntx, cmd_nrx;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        rsp_err = 1'b0;
    logic        done, error;
    logic [1:0]  id_index;
    logic [15:0] part_page, part_blk;
    logic [7:0]  part_spare;

    always #5 clk = ~clk;

    snand_init_seq u_snand_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_valid(cmd_valid), .cmd_bytes(cmd_bytes), .cmd_ntx(cmd_ntx), .cmd_nrx(cmd_nrx),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .done(done), .error(error), .id_index(id_index),
        .part_page(part_page), .part_spare(part_spare), .part_blk(part_blk)
    );

    int checks = 0;
    int fails  = 0;

    // model configuration (set by tests)
    logic [23:0] cfg_id = 24'hEFAA21;
    logic        cfg_ecc_stuck = 1'b0;
    logic        cfg_busy_stuck = 1'b0;
    logic [7:0]  cfg_err_op = 8'h00;

    // model state and log (owned by the model)
    logic [7:0] reg1, reg2;
    int  busy_left, n_cmds, wr1, wr2, order_err, hold_err, first_seen;
    logic [7:0] first_op, die_val;
    logic [2:0] first_ntx, first_nrx, id_ntx, id_nrx;
    logic die_seen, need_poll;

    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                reg1 = 8'hFE; reg2 = 8'h41; busy_left = 0; n_cmds = 0;
                wr1 = 0; wr2 = 0; order_err = 0; hold_err = 0; first_seen = 0;
                first_op = 0; first_ntx = 0; first_nrx = 0; id_ntx = 0; id_nrx = 0;
                die_seen = 0; die_val = 0; need_poll = 0;
            end else if (cmd_valid) begin
                logic [31:0] b;
                logic [2:0]  t, r;
                logic [7:0]  op, ad;
                logic        is_poll;
                b = cmd_bytes; t = cmd_ntx; r = cmd_nrx;
                op = b[31:24]; ad = b[23:16];
                repeat (2) @(negedge clk);
                if (cmd_bytes != b || cmd_ntx != t || cmd_nrx != r || !cmd_valid) hold_err++;
                n_cmds++;
                if (first_seen == 0) begin first_seen = 1; first_op = op; first_ntx = t; first_nrx = r; end
                is_poll = (op == 8'h0F && ad == 8'hC0);
                if (need_poll && !is_poll) order_err++;
                rsp_data = 32'h0;
                case (op)
                    8'hFF: begin busy_left = 2; need_poll = 1; end
                    8'h9F: begin rsp_data = {cfg_id, 8'h55}; id_ntx = t; id_nrx = r; end
                    8'h05: rsp_data = {24'h0, reg1};
                    8'h0F: begin
                        if (ad == 8'hC0) begin
                            rsp_data = {31'h0, (busy_left > 0) || cfg_busy_stuck};
                            if (busy_left > 0) busy_left--;
                            else if (!cfg_busy_stuck) need_poll = 0;
                        end else rsp_data = {24'h0, reg2};
                    end
                    8'h01: begin
                        if (ad == 8'hA0) begin reg1 = b[15:8]; wr1++; end
                        else begin reg2 = cfg_ecc_stuck ? (b[15:8] & 8'hEF) : b[15:8]; wr2++; end
                        busy_left = 2; need_poll = 1;
                    end
                    8'hC2: begin die_seen = 1; die_val = ad; end
                    default: ;
                endcase
                rsp_err = (cfg_err_op != 8'h00) && (op == cfg_err_op);
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_err = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [23:0] id, input bit stuck_ecc, input bit stuck_busy, input logic [7:0] err_op);
        cfg_id = id; cfg_ecc_stuck = stuck_ecc; cfg_busy_stuck = stuck_busy; cfg_err_op = err_op;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done || error) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !error && !cmd_valid, "R9 reset state idle", {done, error, cmd_valid}, 0);
    endtask

    task automatic t_single;
        int nc;
        run(24'hEFAA21, 0, 0, 8'h00);
        chk(done && !error, "R9 single-die done", {done, error}, 2);
        chk(id_index == 2'd0, "R9 index", id_index, 0);
        chk(part_page == 16'd2048 && part_spare == 8'd64 && part_blk == 16'd64, "R9 geometry", part_spare, 64);
        chk(first_op == 8'hFF && first_ntx == 3'd1 && first_nrx == 3'd0, "R1 reset first", first_op, 8'hFF);
        chk(id_ntx == 3'd1 && id_nrx == 3'd4, "R2 id read framing, trailing byte ignored", id_nrx, 4);
        chk(reg1 == 8'h82 && wr1 == 1, "R5 unprotect value", reg1, 8'h82);
        chk(reg2 == 8'h59 && wr2 == 2, "R6 buffer+ecc value", reg2, 8'h59);
        chk(order_err == 0, "R6 poll after write", order_err, 0);
        chk(!die_seen, "R8 no die select single-die", die_seen, 0);
        chk(hold_err == 0, "R12 command held", hold_err, 0);
        nc = n_cmds;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(n_cmds == nc && done, "R1 start ignored after done", n_cmds, nc);
    endtask

    task automatic t_multi;
        run(24'hEFAB21, 0, 0, 8'h00);
        chk(done && !error && id_index == 2'd1, "R9 multi-die done index", id_index, 1);
        chk(die_seen && die_val == 8'h01, "R8 die select number", die_val, 1);
        chk(wr1 == 2 && reg1 == 8'h82, "R8 second unprotect", wr1, 2);
        chk(order_err == 0, "R6 poll order multi", order_err, 0);
    endtask

    task automatic t_unknown;
        run(24'h123456, 0, 0, 8'h00);
        chk(error && !done, "R3 unknown id error", error, 1);
        chk(wr1 + wr2 == 0, "R3 no writes", wr1 + wr2, 0);
    endtask

    task automatic t_vendor;
        run(24'h2C242C, 0, 0, 8'h00);
        chk(error && !done, "R4 foreign vendor error", error, 1);
        chk(wr1 + wr2 == 0, "R4 no writes", wr1 + wr2, 0);
    endtask

    task automatic t_ecc;
        run(24'hEFAB21, 1, 0, 8'h00);
        chk(error && !done, "R7 ecc readback error", error, 1);
        chk(!die_seen && wr1 == 1, "R7 stopped before die select", die_seen, 0);
    endtask

    task automatic t_timeout;
        run(24'hEFAA21, 0, 1, 8'h00);
        chk(error && !done, "R10 poll timeout error", error, 1);
        chk(n_cmds == 17, "R10 poll count", n_cmds, 17);
    endtask

    task automatic t_rsp_err;
        run(24'hEFAA21, 0, 0, 8'h9F);
        chk(error && !done && wr1 + wr2 == 0, "R11 transport error", error, 1);
        repeat (10) @(negedge clk);
        chk(error && !cmd_valid, "R11 error sticky", error, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_unknown();
        t_vendor();
        t_ecc();
        t_timeout();
        t_rsp_err();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule